// File: doc/BRIEF.md
# Quasi-minimal diagonal mesh route selector

This block makes the per-hop output decision for one subnet of a mesh router whose nodes are joined by horizontal, vertical and diagonal links. Each packet header carries the distance to its destination as signed hop counts in X and Y, relative to the current node. For a header flit the selector picks exactly one output port. It favours the diagonal link that closes both distances at once. When that link is congested or its buffer is full, it steps aside onto the horizontal or the vertical link toward the destination. It also rewrites the two offsets so that the next router sees the remaining distance.

A parameter chooses which subnet the instance serves: the eastbound subnet carries packets whose X offset is positive, and the westbound subnet carries packets whose X offset is negative. The chosen port is held for the body flits of the packet until the tail flit has passed. Buffering, the crossbar, arbitration between inputs and link flow control belong to the surrounding router.

Top module: `qmr_route_sel`

## Requirements
- R1: During and right after a synchronous active-low reset, `out_valid` is 0 and `out_port` is all zeros.
- R2: With `EAST`=1 the X offset counts hops toward the east (positive) and a horizontal hop lowers it by one. With `EAST`=0 it counts toward the west (negative) and a horizontal hop raises it by one. An X offset of the opposite sign is treated as zero and is passed on unchanged.
- R3: The port bits are: bit 0 eject, bit 1 horizontal, bit 2 north, bit 3 south, bit 4 north diagonal, bit 5 south diagonal. A positive Y means the destination is north. When X is nonzero in the travel direction, Y is nonzero, and the matching diagonal is not blocked, the matching diagonal is chosen.
- R4: A port counts as blocked when its congestion flag or its full flag is set. When the preferred diagonal is blocked, the horizontal port is taken if it is free. Otherwise the vertical port toward the destination is taken if it is free.
- R5: When the diagonal, the horizontal port and the vertical fallback are all blocked, the request stays on the diagonal.
- R6: When X is zero, only the vertical port toward the destination is requested, whatever the flags say.
- R7: When Y is zero and X is nonzero, only the horizontal port is requested, whatever the flags say.
- R8: When both offsets are zero, the eject port is requested whatever the flags say, and the offsets are passed on unchanged.
- R9: The rewritten offsets reflect the hop. A north hop lowers Y by one and a south hop raises Y by one. A diagonal hop changes both X and Y.
- R10: A body flit requests the port latched by its header. It ignores its own offsets and the flags, and it leaves `out_x` and `out_y` unchanged.
- R11: A flit with the tail flag set releases the latched port. A body flit that arrives with no open packet gives `out_valid`=0. A flit marked both head and tail is routed and then released.
- R12: Outputs register one cycle after the flit is presented. A cycle with no flit gives `out_valid`=0 and `out_port`=0.
- R13: `out_port` never has more than one bit set, and it has exactly one bit set whenever `out_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flit_valid | input | 1 | A flit is presented this cycle |
| flit_head | input | 1 | The flit is a header |
| flit_tail | input | 1 | The flit is the last of its packet |
| in_x | input | OFS_W | Signed X hop offset from the header |
| in_y | input | OFS_W | Signed Y hop offset from the header |
| port_cong | input | 6 | Per-port congestion flags |
| port_full | input | 6 | Per-port buffer-full flags |
| out_valid | output | 1 | A port request is presented |
| out_port | output | 6 | One-hot output port request |
| out_x | output | OFS_W | Rewritten X offset for the next hop |
| out_y | output | OFS_W | Rewritten Y offset for the next hop |

## Verification
The decision path can meet the packet latch in a single cycle in two ways. The first is a flit marked both head and tail: the bench checks that it is routed and that a body flit sent straight after it gets no request. The second is a header routed around a blocked diagonal, followed by body flits during which the flags are changed so that the diagonal is free and the fallback port is blocked. Those body flits must keep requesting the fallback port with the header's rewritten offsets, and the bench reads that at the ports one cycle after each flit.

// File: rtl/qmr_pkg.sv
// Shared port numbering and types for the route selector.
// Assumes six candidate outputs per subnet; bit order is decoded by the crossbar.
package qmr_pkg;
    localparam int NPORT   = 6;
    localparam int P_EJECT = 0;
    localparam int P_HORIZ = 1;
    localparam int P_NORTH = 2;
    localparam int P_SOUTH = 3;
    localparam int P_DIAGN = 4;
    localparam int P_DIAGS = 5;

    typedef logic [NPORT-1:0] port_vec_t;
endpackage

// File: rtl/qmr_dir_decode.sv
// Classifies the signed offsets into wanted movements for one subnet.
// Assumes two's complement offsets; X of the wrong sign counts as zero.
module qmr_dir_decode #(
    parameter int OFS_W = 5,
    parameter bit EAST  = 1'b1
) (
    input  logic signed [OFS_W-1:0] x_ofs,
    input  logic signed [OFS_W-1:0] y_ofs,
    output logic                    x_go,
    output logic                    y_up,
    output logic                    y_dn
);
    localparam logic signed [OFS_W-1:0] ZERO = '0;

    // Derive movement wishes from the offset signs.
    always_comb begin
        if (EAST) begin
            x_go = (x_ofs > ZERO);
        end else begin
            x_go = (x_ofs < ZERO);
        end
        y_up = (y_ofs > ZERO);
        y_dn = (y_ofs < ZERO);
    end
endmodule

// File: rtl/qmr_port_pick.sv
// Quasi-minimal port choice: diagonal first, then horizontal, then vertical.
// Assumes y_up and y_dn are never both set; ejects when no movement is wanted.
module qmr_port_pick
    import qmr_pkg::*;
(
    input  logic      x_go,
    input  logic      y_up,
    input  logic      y_dn,
    input  port_vec_t blocked,
    output port_vec_t pick
);
    logic y_any;
    int   diag_idx;
    int   vert_idx;

    // Pick the diagonal/vertical port pair that matches the Y sign.
    always_comb begin
        y_any    = y_up | y_dn;
        diag_idx = y_up ? P_DIAGN : P_DIAGS;
        vert_idx = y_up ? P_NORTH : P_SOUTH;
    end

    // Choose one output with the fallback order.
    always_comb begin
        pick = '0;
        if (x_go && y_any) begin
            if (!blocked[diag_idx]) begin
                pick[diag_idx] = 1'b1;
            end else if (!blocked[P_HORIZ]) begin
                pick[P_HORIZ] = 1'b1;
            end else if (!blocked[vert_idx]) begin
                pick[vert_idx] = 1'b1;
            end else begin
                pick[diag_idx] = 1'b1;
            end
        end else if (x_go) begin
            pick[P_HORIZ] = 1'b1;
        end else if (y_any) begin
            pick[vert_idx] = 1'b1;
        end else begin
            pick[P_EJECT] = 1'b1;
        end
    end
endmodule

// File: rtl/qmr_offset_step.sv
// Rewrites the relative offsets for the hop selected by the picker.
// Assumes a one-hot pick; the offsets are unchanged for an eject.
module qmr_offset_step
    import qmr_pkg::*;
#(
    parameter int OFS_W = 5,
    parameter bit EAST  = 1'b1
) (
    input  logic signed [OFS_W-1:0] x_ofs,
    input  logic signed [OFS_W-1:0] y_ofs,
    input  port_vec_t               pick,
    output logic signed [OFS_W-1:0] x_nxt,
    output logic signed [OFS_W-1:0] y_nxt
);
    localparam logic signed [OFS_W-1:0] ONE    = 1;
    localparam logic signed [OFS_W-1:0] X_STEP = EAST ? ONE : -ONE;

    logic moves_x;
    logic moves_n;
    logic moves_s;

    // Which axes this hop advances.
    always_comb begin
        moves_x = pick[P_HORIZ] | pick[P_DIAGN] | pick[P_DIAGS];
        moves_n = pick[P_NORTH] | pick[P_DIAGN];
        moves_s = pick[P_SOUTH] | pick[P_DIAGS];
    end

    // Apply the hop to the remaining distance.
    always_comb begin
        x_nxt = moves_x ? (x_ofs - X_STEP) : x_ofs;
        if (moves_n) begin
            y_nxt = y_ofs - ONE;
        end else if (moves_s) begin
            y_nxt = y_ofs + ONE;
        end else begin
            y_nxt = y_ofs;
        end
    end
endmodule

// File: rtl/qmr_route_sel.sv
// Per-hop route selector for one subnet of a diagonally linked mesh router.
// Routes header flits, latches the port for body flits until the tail, and
// registers the request and rewritten offsets one cycle after the flit.
// Assumes the neighbouring logic presents flits in order, one per cycle.
module qmr_route_sel
    import qmr_pkg::*;
#(
    parameter int OFS_W = 5,
    parameter bit EAST  = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flit_valid,
    input  logic                    flit_head,
    input  logic                    flit_tail,
    input  logic signed [OFS_W-1:0] in_x,
    input  logic signed [OFS_W-1:0] in_y,
    input  logic [NPORT-1:0]        port_cong,
    input  logic [NPORT-1:0]        port_full,
    output logic                    out_valid,
    output logic [NPORT-1:0]        out_port,
    output logic signed [OFS_W-1:0] out_x,
    output logic signed [OFS_W-1:0] out_y
);
    port_vec_t               blocked;
    port_vec_t               pick;
    port_vec_t               held_port;
    logic                    x_go;
    logic                    y_up;
    logic                    y_dn;
    logic signed [OFS_W-1:0] x_nxt;
    logic signed [OFS_W-1:0] y_nxt;
    logic                    is_head;
    logic                    is_body;

    // Merge congestion and full flags per port.
    for (genvar g = 0; g < NPORT; g++) begin : g_blk
        assign blocked[g] = port_cong[g] | port_full[g];
    end

    qmr_dir_decode #(.OFS_W(OFS_W), .EAST(EAST)) u_dec (
        .x_ofs (in_x),
        .y_ofs (in_y),
        .x_go  (x_go),
        .y_up  (y_up),
        .y_dn  (y_dn)
    );

    qmr_port_pick u_pick (
        .x_go    (x_go),
        .y_up    (y_up),
        .y_dn    (y_dn),
        .blocked (blocked),
        .pick    (pick)
    );

    qmr_offset_step #(.OFS_W(OFS_W), .EAST(EAST)) u_step (
        .x_ofs (in_x),
        .y_ofs (in_y),
        .pick  (pick),
        .x_nxt (x_nxt),
        .y_nxt (y_nxt)
    );

    // Classify the current flit.
    always_comb begin
        is_head = flit_valid & flit_head;
        is_body = flit_valid & ~flit_head;
    end

    // Hold the packet's port from header to tail.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_port <= '0;
        end else if (is_head) begin
            held_port <= flit_tail ? '0 : pick;
        end else if (is_body && flit_tail) begin
            held_port <= '0;
        end
    end

    // Register the request and the rewritten offsets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_port  <= '0;
            out_x     <= '0;
            out_y     <= '0;
        end else if (is_head) begin
            out_valid <= 1'b1;
            out_port  <= pick;
            out_x     <= x_nxt;
            out_y     <= y_nxt;
        end else if (is_body) begin
            out_valid <= |held_port;
            out_port  <= held_port;
        end else begin
            out_valid <= 1'b0;
            out_port  <= '0;
        end
    end

    // R13: at most one port, exactly one when valid.
    p_onehot_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_port) && (out_valid -> ($countones(out_port) == 1)));

    // R12: no request without a preceding flit.
    p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !flit_valid |=> (!out_valid && out_port == '0));

    // R10: body flits reuse the latched port.
    p_body_r10: assert property (@(posedge clk) disable iff (!rst_n)
        is_body |=> (out_port == $past(held_port)));

    // R8: ejection leaves the offsets untouched.
    p_eject_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_head && !x_go && !y_up && !y_dn) |=>
        (out_port[P_EJECT] && out_x == $past(in_x) && out_y == $past(in_y)));

    // R3: a free diagonal is always taken when both axes move.
    p_diag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_head && x_go && y_up && !blocked[P_DIAGN]) |=> out_port[P_DIAGN]);

    // R4: horizontal is the first fallback.
    p_fallback_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_head && x_go && y_dn && blocked[P_DIAGS] && !blocked[P_HORIZ])
        |=> out_port[P_HORIZ]);

    // R11: the latch is empty after a tail flit.
    p_tail_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (flit_valid && flit_tail) |=> (held_port == '0));
endmodule

// File: tb/qmr_route_sel_tb.sv
module qmr_route_sel_tb;
    localparam int W = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flit_valid = 1'b0;
    logic          flit_head = 1'b0;
    logic          flit_tail = 1'b0;
    logic [W-1:0]  in_x = '0;
    logic [W-1:0]  in_y = '0;
    logic [5:0]    port_cong = '0;
    logic [5:0]    port_full = '0;
    logic          out_valid, w_valid;
    logic [5:0]    out_port, w_port;
    logic [W-1:0]  out_x, out_y, w_x, w_y;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    qmr_route_sel #(.OFS_W(W), .EAST(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .flit_valid(flit_valid), .flit_head(flit_head),
        .flit_tail(flit_tail), .in_x(in_x), .in_y(in_y), .port_cong(port_cong),
        .port_full(port_full), .out_valid(out_valid), .out_port(out_port),
        .out_x(out_x), .out_y(out_y));

    qmr_route_sel #(.OFS_W(W), .EAST(1'b0)) u_dut_west (
        .clk(clk), .rst_n(rst_n), .flit_valid(flit_valid), .flit_head(flit_head),
        .flit_tail(flit_tail), .in_x(in_x), .in_y(in_y), .port_cong(port_cong),
        .port_full(port_full), .out_valid(w_valid), .out_port(w_port),
        .out_x(w_x), .out_y(w_y));

    // {x, y, blocked, expected port, expected x, expected y}
    localparam int NV = 14;
    localparam logic [31:0] VEC [NV] = '{
        {5'(3),  5'(2),  6'b000000, 6'b010000, 5'(2),  5'(1)},   // R3 R9
        {5'(3),  5'(-2), 6'b000000, 6'b100000, 5'(2),  5'(-1)},  // R3 R9
        {5'(3),  5'(2),  6'b010000, 6'b000010, 5'(2),  5'(2)},   // R4
        {5'(3),  5'(2),  6'b010010, 6'b000100, 5'(3),  5'(1)},   // R4
        {5'(3),  5'(-2), 6'b100010, 6'b001000, 5'(3),  5'(-1)},  // R4
        {5'(3),  5'(2),  6'b111111, 6'b010000, 5'(2),  5'(1)},   // R5
        {5'(0),  5'(4),  6'b000000, 6'b000100, 5'(0),  5'(3)},   // R6
        {5'(0),  5'(4),  6'b000100, 6'b000100, 5'(0),  5'(3)},   // R6
        {5'(0),  5'(-1), 6'b001000, 6'b001000, 5'(0),  5'(0)},   // R6
        {5'(5),  5'(0),  6'b000010, 6'b000010, 5'(4),  5'(0)},   // R7
        {5'(0),  5'(0),  6'b111111, 6'b000001, 5'(0),  5'(0)},   // R8
        {5'(-2), 5'(3),  6'b000000, 6'b000100, 5'(-2), 5'(2)},   // R2
        {5'(1),  5'(1),  6'b010000, 6'b000010, 5'(0),  5'(1)},   // R4
        {5'(15), 5'(-16),6'b000000, 6'b100000, 5'(14), 5'(-15)}  // R9
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one flit on the falling edge, then sample after the next rise.
    task automatic send(input logic v, input logic h, input logic t,
                        input logic [W-1:0] x, input logic [W-1:0] y,
                        input logic [5:0] c, input logic [5:0] f);
        @(negedge clk);
        flit_valid = v; flit_head = h; flit_tail = t;
        in_x = x; in_y = y; port_cong = c; port_full = f;
        @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        #200000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1;
        chk("R1 valid in reset", {31'd0, out_valid}, 32'd0);
        chk("R1 port in reset", {26'd0, out_port}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        send(1'b0, 1'b0, 1'b0, '0, '0, '0, '0);
        chk("R1 after reset", {25'd0, out_valid, out_port}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [31:0] v;
            v = VEC[i];
            send(1'b1, 1'b1, 1'b1, v[31:27], v[26:22], v[21:16], 6'b0);
            chk("R3-table valid", {31'd0, out_valid}, 32'd1);
            chk("R3 R4 R5 R6 R7 R8 port", {26'd0, out_port}, {26'd0, v[15:10]});
            chk("R9 offsets", {22'd0, out_x, out_y}, {22'd0, v[9:0]});
        end

        // R4: full flag blocks like congestion
        send(1'b1, 1'b1, 1'b1, 5'(2), 5'(2), 6'b0, 6'b010000);
        chk("R4 full flag fallback", {26'd0, out_port}, 32'h2);

        // R12: no flit gives no request
        send(1'b0, 1'b0, 1'b0, 5'(3), 5'(3), '0, '0);
        chk("R12 idle", {25'd0, out_valid, out_port}, 32'd0);

        // R10: header around blocked diagonal, then body with changed flags
        send(1'b1, 1'b1, 1'b0, 5'(3), 5'(2), 6'b010000, 6'b0);
        chk("R10 header port", {26'd0, out_port}, 32'h2);
        send(1'b1, 1'b0, 1'b0, 5'(0), 5'(0), 6'b000010, 6'b000010);
        chk("R10 body port", {25'd0, out_valid, out_port}, {25'd0, 1'b1, 6'h2});
        chk("R10 body offsets", {22'd0, out_x, out_y}, {22'd0, 5'(2), 5'(2)});
        send(1'b0, 1'b0, 1'b0, '0, '0, '0, '0);
        chk("R12 gap in packet", {25'd0, out_valid, out_port}, 32'd0);
        send(1'b1, 1'b0, 1'b1, 5'(7), 5'(-3), 6'b111111, 6'b0);
        chk("R11 tail keeps port", {25'd0, out_valid, out_port}, {25'd0, 1'b1, 6'h2});
        send(1'b1, 1'b0, 1'b0, '0, '0, '0, '0);
        chk("R11 body after tail", {25'd0, out_valid, out_port}, 32'd0);

        // R11: head and tail in one flit, body after it has no packet
        send(1'b1, 1'b1, 1'b1, 5'(0), 5'(0), '0, '0);
        chk("R11 single flit eject", {26'd0, out_port}, 32'h1);
        send(1'b1, 1'b0, 1'b0, '0, '0, '0, '0);
        chk("R11 stray body", {31'd0, out_valid}, 32'd0);

        // R2: westbound subnet
        send(1'b1, 1'b1, 1'b1, 5'(-3), 5'(2), '0, '0);
        chk("R2 west diagonal", {26'd0, w_port}, 32'h10);
        chk("R2 west offsets", {22'd0, w_x, w_y}, {22'd0, 5'(-2), 5'(1)});
        send(1'b1, 1'b1, 1'b1, 5'(-3), 5'(0), '0, '0);
        chk("R2 west horizontal", {22'd0, w_x, w_y}, {22'd0, 5'(-2), 5'(0)});
        chk("R7 west port", {26'd0, w_port}, 32'h2);

        // R1: reset mid-packet clears outputs
        send(1'b1, 1'b1, 1'b0, 5'(1), 5'(1), '0, '0);
        @(negedge clk);
        rst_n = 1'b0;
        flit_valid = 1'b0;
        @(posedge clk);
        #1;
        chk("R1 reset mid packet", {25'd0, out_valid, out_port}, 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule